// File: doc/BRIEF.md
# Drowsy Cache Set Wake Controller

This block keeps one awake/drowsy flag for every set of a set-associative data cache. Sets drift into a low-leakage drowsy state all at once: a free-running window timer puts every set to sleep at the end of each window. A load that reaches a drowsy set cannot be served at the normal fixed latency. The block wakes every way of that set together, holds the cache port for one more cycle, and raises a flag that tells the scheduler to treat the load as non-deterministic. Speculatively issued consumers can then be replayed.

A second request port lets an earlier pipeline stage wake a set one cycle ahead of the load. An example is an address stage that already knows the index will not change when the displacement is added. When that port is used, the load finds the set awake and sees no penalty. Two saturating counters report how many loads were accepted and how many of them hit a drowsy set, which gives the drowsy rate.

Top module: `drowsy_wake_ctrl`

## Requirements
- R1: After reset every set is drowsy, `port_busy` is 0, both counters are 0 and the window timer starts from zero.
- R2: An accepted load to an awake set drives `ld_on_time`=1 and `ld_nondet`=0 in the same cycle.
- R3: An accepted load to a drowsy set drives `ld_nondet`=1 and `ld_on_time`=0 in the same cycle, and that whole set is awake from the next clock edge.
- R4: `port_busy` is 1 in the cycle after a drowsy load. A load presented while `port_busy`=1 is ignored: both flags stay 0, it wakes nothing and it is not counted.
- R5: A wake request on `pre_valid`/`pre_set` makes that set awake from the next clock edge, so a load to it one cycle later is on time.
- R6: The clock edge that ends every DROWSE_WINDOW-th cycle after reset makes every set drowsy.
- R7: If a wake (from a drowsy load or from the early port) falls in the same cycle as the global drowse, the woken set ends up awake.
- R8: `ld_total` counts accepted loads and `ld_drowsy` counts loads that raised `ld_nondet`. Both are registered, are visible the cycle after the load, and hold at all ones once they get there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load presents a set index this cycle |
| ld_set | input | SET_W | Set index of the load |
| pre_valid | input | 1 | Early wake request valid |
| pre_set | input | SET_W | Set index to wake early |
| ld_on_time | output | 1 | The load is accepted and its set is awake (normal latency) |
| ld_nondet | output | 1 | The load is accepted but its set is drowsy; signal to the scheduler |
| port_busy | output | 1 | The port is held for the wake-up cycle; loads are ignored |
| ld_total | output | CNT_W | Saturating count of accepted loads |
| ld_drowsy | output | CNT_W | Saturating count of drowsy loads |

## Verification
Directed loads go first to a set that has just come out of reset and then to the same set again. This separates the drowsy-penalty path from the on-time path. A load held during the busy cycle and then repeated shows that a blocked load wakes nothing. The bench places early wakes and load wakes exactly on the drowse edge, which tells wake-wins-over-drowse apart from a plain periodic drowse. A long random mix of loads and early wakes over few sets drives the counters to saturation. A reference model tracks the awake state and the window phase cycle by cycle for the whole run.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  typedef enum logic [1:0] {
    OUT_IDLE    = 2'd0,
    OUT_FAST    = 2'd1,
    OUT_SLOW    = 2'd2,
    OUT_BLOCKED = 2'd3
  } ld_outcome_e;

  // Classify one load slot from its request, the port hold and the set state.
  function automatic ld_outcome_e classify(input logic valid,
                                           input logic busy,
                                           input logic set_awake);
    if (!valid)         return OUT_IDLE;
    else if (busy)      return OUT_BLOCKED;
    else if (set_awake) return OUT_FAST;
    else                return OUT_SLOW;
  endfunction

endpackage

// File: rtl/dwc_window_timer.sv
module dwc_window_timer #(
  parameter int WINDOW = 2000
) (
  input  logic clk,
  input  logic rst_n,
  output logic drowse_tick
);
  localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] phase_q;

  function automatic logic [CW-1:0] next_phase(input logic [CW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign drowse_tick = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= next_phase(phase_q);
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST); // R6
  AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    drowse_tick |=> (phase_q == '0)); // R6
endmodule

// File: rtl/dwc_set_state.sv
module dwc_set_state #(
  parameter int NUM_SETS = 64,
  parameter int SET_W    = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wake_a_vld,
  input  logic [SET_W-1:0]    wake_a_set,
  input  logic                wake_b_vld,
  input  logic [SET_W-1:0]    wake_b_set,
  input  logic                drowse_tick,
  output logic [NUM_SETS-1:0] awake_vec
);
  logic [NUM_SETS-1:0] wake_hit;

  for (genvar i = 0; i < NUM_SETS; i++) begin : g_set
    assign wake_hit[i] = (wake_a_vld && (wake_a_set == SET_W'(i))) ||
                         (wake_b_vld && (wake_b_set == SET_W'(i)));

    // A wake of the whole set wins over the global drowse.
    always_ff @(posedge clk) begin
      if (!rst_n)            awake_vec[i] <= 1'b0;
      else if (wake_hit[i])  awake_vec[i] <= 1'b1;
      else if (drowse_tick)  awake_vec[i] <= 1'b0;
    end

    AST_WAKE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wake_hit[i] |=> awake_vec[i]); // R7
    AST_DROWSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (drowse_tick && !wake_hit[i]) |=> !awake_vec[i]); // R6
    AST_RISE_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(awake_vec[i]) |-> $past(wake_hit[i])); // R5
  end
endmodule

// File: rtl/dwc_access_ctrl.sv
module dwc_access_ctrl
  import dwc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             set_awake,
  output logic             ld_on_time,
  output logic             ld_nondet,
  output logic             port_busy,
  output logic             ld_accept,
  output logic [CNT_W-1:0] ld_total,
  output logic [CNT_W-1:0] ld_drowsy
);
  ld_outcome_e outcome;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic en);
    return (en && (v != '1)) ? v + 1'b1 : v;
  endfunction

  assign outcome    = classify(ld_valid, port_busy, set_awake);
  assign ld_on_time = (outcome == OUT_FAST);
  assign ld_nondet  = (outcome == OUT_SLOW);
  assign ld_accept  = ld_on_time || ld_nondet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_busy <= 1'b0;
      ld_total  <= '0;
      ld_drowsy <= '0;
    end else begin
      port_busy <= ld_nondet;
      ld_total  <= sat_inc(ld_total, ld_accept);
      ld_drowsy <= sat_inc(ld_drowsy, ld_nondet);
    end
  end

  AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_nondet |=> port_busy); // R4
  AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |-> (!ld_nondet && !ld_on_time)); // R4
  AST_TOTAL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ld_total >= $past(ld_total))); // R8
  AST_DROWSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ld_drowsy <= ld_total); // R8
endmodule

// File: rtl/drowsy_wake_ctrl.sv
module drowsy_wake_ctrl #(
  parameter int NUM_SETS      = 64,
  parameter int DROWSE_WINDOW = 2000,
  parameter int CNT_W         = 16,
  localparam int SET_W        = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [SET_W-1:0] ld_set,
  input  logic             pre_valid,
  input  logic [SET_W-1:0] pre_set,
  output logic             ld_on_time,
  output logic             ld_nondet,
  output logic             port_busy,
  output logic [CNT_W-1:0] ld_total,
  output logic [CNT_W-1:0] ld_drowsy
);
  logic                drowse_tick;
  logic [NUM_SETS-1:0] awake_vec;
  logic                sel_awake;
  logic                ld_accept;

  assign sel_awake = awake_vec[ld_set];

  dwc_window_timer #(.WINDOW(DROWSE_WINDOW)) u_timer (
    .clk(clk), .rst_n(rst_n), .drowse_tick(drowse_tick)
  );

  dwc_set_state #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_sets (
    .clk(clk), .rst_n(rst_n),
    .wake_a_vld(ld_nondet), .wake_a_set(ld_set),
    .wake_b_vld(pre_valid), .wake_b_set(pre_set),
    .drowse_tick(drowse_tick), .awake_vec(awake_vec)
  );

  dwc_access_ctrl #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .set_awake(sel_awake),
    .ld_on_time(ld_on_time), .ld_nondet(ld_nondet),
    .port_busy(port_busy), .ld_accept(ld_accept),
    .ld_total(ld_total), .ld_drowsy(ld_drowsy)
  );

  AST_SLOW_WAKES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ld_nondet |=> awake_vec[$past(ld_set)]); // R3
  AST_FAST_NEEDS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_on_time |-> awake_vec[ld_set]); // R2
  AST_ACCEPT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_accept && (ld_total != '1)) |=> (ld_total != $past(ld_total))); // R8
endmodule

// File: tb/drowsy_wake_ctrl_tb_top.sv
module drowsy_wake_ctrl_tb_top;
  localparam int NS  = 16;
  localparam int SW  = 4;
  localparam int WIN = 40;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, pre_valid = 1'b0;
  logic [SW-1:0] ld_set = '0, pre_set = '0;
  logic ld_on_time, ld_nondet, port_busy;
  logic [CW-1:0] ld_total, ld_drowsy;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  drowsy_wake_ctrl #(.NUM_SETS(NS), .DROWSE_WINDOW(WIN), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_set(ld_set),
    .pre_valid(pre_valid), .pre_set(pre_set), .ld_on_time(ld_on_time),
    .ld_nondet(ld_nondet), .port_busy(port_busy),
    .ld_total(ld_total), .ld_drowsy(ld_drowsy)
  );

  // Reference model built from the requirements.
  bit m_awake [NS];
  int m_win = 0;
  bit m_busy = 0;
  int m_acc = 0, m_drw = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) m_awake[s] = 0;
      m_win = 0; m_busy = 0; m_acc = 0; m_drw = 0;
    end else begin
      bit take, slow, tick;
      take = ld_valid && !m_busy;
      slow = take && !m_awake[ld_set];
      tick = (m_win == WIN - 1);
      if (take && m_acc < 255) m_acc++;
      if (slow && m_drw < 255) m_drw++;
      for (int s = 0; s < NS; s++) begin
        if ((slow && ld_set == SW'(s)) || (pre_valid && pre_set == SW'(s)))
          m_awake[s] = 1;
        else if (tick)
          m_awake[s] = 0;
      end
      m_win = tick ? 0 : m_win + 1;
      m_busy = slow;
    end
  end

  // Scoreboard queues.
  bit q_rdy[$], q_nd[$], q_busy[$];
  int q_acc[$], q_drw[$];
  string q_req[$];

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit av, input int as, input bit ev, input int es,
                      input string req);
    bit take;
    @(negedge clk);
    ld_valid = av; ld_set = SW'(as); pre_valid = ev; pre_set = SW'(es);
    take = av && !m_busy;
    q_rdy.push_back(take && m_awake[as]);
    q_nd.push_back(take && !m_awake[as]);
    q_busy.push_back(m_busy);
    q_acc.push_back(m_acc);
    q_drw.push_back(m_drw);
    q_req.push_back(req);
  endtask

  // Monitor: compares the outputs shortly after each falling edge.
  always @(negedge clk) begin
    #2;
    if (q_req.size() > 0) begin
      string r;
      r = q_req.pop_front();
      check(r, int'(ld_on_time), int'(q_rdy.pop_front()), "ld_on_time");
      check(r, int'(ld_nondet), int'(q_nd.pop_front()), "ld_nondet");
      check("R4", int'(port_busy), int'(q_busy.pop_front()), "port_busy");
      check("R8", int'(ld_total), q_acc.pop_front(), "ld_total");
      check("R8", int'(ld_drowsy), q_drw.pop_front(), "ld_drowsy");
    end
  end

  task automatic wait_tick_cycle();
    while (m_win != WIN - 1) step(0, 0, 0, 0, "R6");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", int'(port_busy), 0, "port_busy in reset");
    check("R1", int'(ld_total), 0, "ld_total in reset");
    check("R1", int'(ld_drowsy), 0, "ld_drowsy in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 3, 0, 0, "R1");   // set drowsy after reset
    step(1, 5, 0, 0, "R4");   // blocked during busy
    step(1, 3, 0, 0, "R3");   // set 3 now awake
    step(1, 5, 0, 0, "R4");   // set 5 still drowsy: blocked load woke nothing
    step(0, 0, 0, 0, "R4");
    step(1, 3, 0, 0, "R2");
    step(0, 0, 1, 9, "R5");
    step(1, 9, 0, 0, "R5");
    step(1, 3, 1, 12, "R2");
    step(1, 12, 0, 0, "R5");
    // early wake on the drowse edge
    wait_tick_cycle();
    step(0, 0, 1, 7, "R7");
    step(1, 3, 0, 0, "R6");   // set 3 put to sleep
    step(0, 0, 0, 0, "R6");
    step(1, 7, 0, 0, "R7");   // set 7 survived the drowse
    // load wake on the drowse edge
    while (m_win != WIN - 1 || m_busy) step(0, 0, 0, 0, "R6");
    step(1, 11, 0, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(1, 11, 0, 0, "R7");
    // random mix, drives counters to saturation
    for (int n = 0; n < 900; n++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 5),
           $urandom_range(0, 4) == 0, $urandom_range(0, 7), "R8");
    step(0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    @(negedge clk); #3;
    check("R8", int'(ld_total), 255, "ld_total saturated");
    check("R8", int'(ld_drowsy), m_drw, "ld_drowsy final");
    finish_run();
  end
endmodule